// File: doc/BRIEF.md
# Read-Request Tag and Completion Tracker

This block sits between user logic that issues memory reads on a packet-based link and the path that returns completions. For every read the user wants to send, it hands out a tag and sets aside completion buffer space: one header slot, plus one data slot for every 16 bytes requested. A request that cannot get a tag, or would not fit in the free completion space, is held back by the request handshake. From then on, every completion beat that comes back is checked against the tag table. Beats for a live tag are accepted. Beats for a tag nobody is waiting on are dropped.

Each outstanding tag runs its own down-counter, loaded from a programmable cycle count when the tag is issued. If the final completion has not arrived when the counter runs out, the request is abandoned. The block then pulses a timeout indication with the tag and gives back the reserved space at once. The tag stays poisoned: any late completion carrying it is thrown away until the tag is handed out again. When an accepted completion has its last flag set, the tag goes back to free and its space is returned.

Top module: `rd_tag_tracker`

## Requirements
- R1: After reset all tags are free, `hdr_free` is 16, `data_free` is 256, `cpl_accept`, `cpl_drop` and `tmo_pulse` are low, and a request is offered tag 0.
- R2: `req_ready` is high only when a tag is available, `hdr_free` is at least 1 and `data_free` is at least ceil(`req_bytes`/16). A request taken at a clock edge lowers `hdr_free` by 1 and `data_free` by that amount at the same edge.
- R3: `req_tag` shows the lowest-numbered tag that is either free or poisoned. Reissuing a poisoned tag clears its poison.
- R4: A completion beat whose tag is outstanding raises `cpl_accept` for one cycle after the edge where it is presented. A beat without the last flag leaves the tag outstanding.
- R5: An accepted beat with `cpl_last` high frees its tag and returns 1 header credit and that request's data credits at the same edge.
- R6: A completion beat for a free tag raises `cpl_drop` for one cycle and changes no credit count. `cpl_accept` and `cpl_drop` are never high together.
- R7: A request taken at edge E with timeout value T (sampled at E), and still outstanding, produces `tmo_pulse` with `tmo_tag` equal to its tag in the cycle after edge E+T and not before. The tag becomes poisoned and its credits are returned at that edge.
- R8: A completion for a poisoned tag is dropped. After the tag is reissued, completions for it are accepted again.
- R9: When a request takes a tag in the same cycle that a completion for that tag arrives, the completion is judged against the tag's state before the allocation.
- R10: When several tags expire in the same cycle, one timeout is reported per cycle, lowest tag first. The others wait without losing their timeout.
- R11: An accepted last completion presented at the edge where its tag would time out wins: the tag is freed and no timeout is reported for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timeout_cycles | input | 16 | Timeout length in cycles, loaded into a tag's timer when it is issued |
| req_valid | input | 1 | User has a read request to send |
| req_bytes | input | 13 | Byte length of the read request |
| req_ready | output | 1 | Request can be taken this cycle (tag and credits available) |
| req_tag | output | 5 | Tag assigned to the request if taken this cycle |
| cpl_valid | input | 1 | A completion beat is present |
| cpl_tag | input | 5 | Tag carried by the completion beat |
| cpl_last | input | 1 | Beat is the final one for its request |
| cpl_accept | output | 1 | Registered: previous beat matched an outstanding tag |
| cpl_drop | output | 1 | Registered: previous beat was discarded |
| tmo_pulse | output | 1 | Registered one-cycle timeout indication |
| tmo_tag | output | 5 | Tag that timed out, valid with `tmo_pulse` |
| hdr_free | output | 5 | Free completion header credits |
| data_free | output | 9 | Free completion data credits |

## Verification
The hardest situations to reach are the ones where timing events collide. One is two tags running out in the same cycle. Another is a final completion arriving exactly on the expiry edge. A third is a poisoned tag being reissued while a stale completion for it arrives. Because the timeout is sampled per request, the bench issues one tag with a count one larger than the next, so both timers reach zero on the same edge. It places completions on precisely counted edges so they land on the expiry edge or on the reissue edge.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [1:0] {
    TAG_FREE   = 2'd0,
    TAG_PEND   = 2'd1,
    TAG_POISON = 2'd2
  } tag_state_e;
endpackage

// File: rtl/rtt_lowest_pick.sv
// Priority pick of the lowest set bit in a mask.
module rtt_lowest_pick #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rtt_timer_bank.sv
// One completion-timeout down-counter per tag.
module rtt_timer_bank #(
  parameter int NUM_TAGS = 32,
  parameter int TAG_W    = $clog2(NUM_TAGS),
  parameter int TMR_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic [TAG_W-1:0]    load_tag,
  input  logic [TMR_W-1:0]    load_val,
  input  logic [NUM_TAGS-1:0] run_mask,
  output logic [NUM_TAGS-1:0] expire_mask
);
  logic [TMR_W-1:0] cnt_q [NUM_TAGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NUM_TAGS; t++) cnt_q[t] <= '0;
    end else begin
      for (int t = 0; t < NUM_TAGS; t++) begin
        if (load_en && load_tag == TAG_W'(t))
          cnt_q[t] <= load_val;
        else if (run_mask[t] && cnt_q[t] > TMR_W'(1))
          cnt_q[t] <= cnt_q[t] - TMR_W'(1);
      end
    end
  end

  // A running timer at one (or zero) has run out; it holds there until served.
  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_exp
    assign expire_mask[g] = run_mask[g] && (cnt_q[g] <= TMR_W'(1));
  end

  // R3: a tag being issued is never one whose timer is running out
  load_not_expiring_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |-> !expire_mask[load_tag]);
endmodule

// File: rtl/rtt_credit_pool.sv
// Completion header/data credit counters with one take and two returns per cycle.
module rtt_credit_pool #(
  parameter int HDR_CAP  = 16,
  parameter int DATA_CAP = 256,
  parameter int HW       = $clog2(HDR_CAP + 1),
  parameter int DW       = $clog2(DATA_CAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_en,
  input  logic [DW-1:0] take_data,
  input  logic          ret_a_en,
  input  logic [DW-1:0] ret_a_data,
  input  logic          ret_b_en,
  input  logic [DW-1:0] ret_b_data,
  output logic [HW-1:0] hdr_free,
  output logic [DW-1:0] data_free
);
  localparam int HX = HW + 2;
  localparam int DX = DW + 2;

  logic [HX-1:0] hdr_nxt;
  logic [DX-1:0] data_nxt;

  always_comb begin
    hdr_nxt  = HX'(hdr_free) + HX'(ret_a_en) + HX'(ret_b_en) - HX'(take_en);
    data_nxt = DX'(data_free)
             + (ret_a_en ? DX'(ret_a_data) : '0)
             + (ret_b_en ? DX'(ret_b_data) : '0)
             - (take_en  ? DX'(take_data)  : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_free  <= HW'(HDR_CAP);
      data_free <= DW'(DATA_CAP);
    end else begin
      hdr_free  <= HW'(hdr_nxt);
      data_free <= DW'(data_nxt);
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (hdr_free <= HW'(HDR_CAP)) && (data_free <= DW'(DATA_CAP)));
  // R2
  take_fits_chk: assert property (@(posedge clk) disable iff (rst)
    take_en |-> (hdr_free != '0) && (data_free >= take_data));
endmodule

// File: rtl/rd_tag_tracker.sv
module rd_tag_tracker #(
  parameter int NUM_TAGS   = 32,
  parameter int HDR_CAP    = 16,
  parameter int DATA_CAP   = 256,
  parameter int CRED_BYTES = 16,
  parameter int BYTES_W    = 13,
  parameter int TMR_W      = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [TMR_W-1:0]                   timeout_cycles,
  input  logic                               req_valid,
  input  logic [BYTES_W-1:0]                 req_bytes,
  output logic                               req_ready,
  output logic [$clog2(NUM_TAGS)-1:0]        req_tag,
  input  logic                               cpl_valid,
  input  logic [$clog2(NUM_TAGS)-1:0]        cpl_tag,
  input  logic                               cpl_last,
  output logic                               cpl_accept,
  output logic                               cpl_drop,
  output logic                               tmo_pulse,
  output logic [$clog2(NUM_TAGS)-1:0]        tmo_tag,
  output logic [$clog2(HDR_CAP + 1)-1:0]     hdr_free,
  output logic [$clog2(DATA_CAP + 1)-1:0]    data_free
);
  import rtt_pkg::*;

  localparam int TAG_W = $clog2(NUM_TAGS);
  localparam int HW    = $clog2(HDR_CAP + 1);
  localparam int DW    = $clog2(DATA_CAP + 1);
  localparam int SH    = $clog2(CRED_BYTES);
  localparam int NW    = BYTES_W + 1;
  localparam int CW    = (NW > DW) ? NW : DW;

  tag_state_e           st_q [NUM_TAGS];
  logic [DW-1:0]        dcred_q [NUM_TAGS];
  logic [NUM_TAGS-1:0]  pend_mask, avail_mask, expire_mask, done_oh, tmo_cand;
  logic [NW-1:0]        need;
  logic                 alloc_found, fire, cpl_hit, cpl_done, tmo_hit;
  logic [TAG_W-1:0]     tmo_idx;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_mask
    assign pend_mask[g]  = (st_q[g] == TAG_PEND);
    assign avail_mask[g] = (st_q[g] != TAG_PEND);
  end

  // Request side: tag pick and credit fit
  rtt_lowest_pick #(.N(NUM_TAGS), .IW(TAG_W)) u_alloc_pick (
    .mask(avail_mask), .found(alloc_found), .idx(req_tag));

  assign need      = (NW'(req_bytes) + NW'(CRED_BYTES - 1)) >> SH;
  assign req_ready = alloc_found && (hdr_free != '0) && (CW'(need) <= CW'(data_free));
  assign fire      = req_valid && req_ready;

  // Completion side: judged against the state before this edge's updates
  assign cpl_hit  = cpl_valid && (st_q[cpl_tag] == TAG_PEND);
  assign cpl_done = cpl_hit && cpl_last;
  assign done_oh  = cpl_done ? (NUM_TAGS'(1) << cpl_tag) : '0;

  rtt_timer_bank #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W), .TMR_W(TMR_W)) u_timers (
    .clk(clk), .rst(rst), .load_en(fire), .load_tag(req_tag),
    .load_val(timeout_cycles), .run_mask(pend_mask), .expire_mask(expire_mask));

  // A finishing completion takes precedence over its own timeout
  assign tmo_cand = expire_mask & ~done_oh;

  rtt_lowest_pick #(.N(NUM_TAGS), .IW(TAG_W)) u_tmo_pick (
    .mask(tmo_cand), .found(tmo_hit), .idx(tmo_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NUM_TAGS; t++) st_q[t] <= TAG_FREE;
    end else begin
      for (int t = 0; t < NUM_TAGS; t++) begin
        if (fire && req_tag == TAG_W'(t))
          st_q[t] <= TAG_PEND;
        else if (cpl_done && cpl_tag == TAG_W'(t))
          st_q[t] <= TAG_FREE;
        else if (tmo_hit && tmo_idx == TAG_W'(t))
          st_q[t] <= TAG_POISON;
      end
    end
  end

  // Per-tag data reservation, RAM style (write on issue, read on release)
  always_ff @(posedge clk) begin
    if (fire) dcred_q[req_tag] <= DW'(need);
  end

  rtt_credit_pool #(.HDR_CAP(HDR_CAP), .DATA_CAP(DATA_CAP), .HW(HW), .DW(DW)) u_credits (
    .clk(clk), .rst(rst),
    .take_en(fire), .take_data(DW'(need)),
    .ret_a_en(cpl_done), .ret_a_data(dcred_q[cpl_tag]),
    .ret_b_en(tmo_hit),  .ret_b_data(dcred_q[tmo_idx]),
    .hdr_free(hdr_free), .data_free(data_free));

  always_ff @(posedge clk) begin
    if (rst) begin
      cpl_accept <= 1'b0;
      cpl_drop   <= 1'b0;
      tmo_pulse  <= 1'b0;
      tmo_tag    <= '0;
    end else begin
      cpl_accept <= cpl_hit;
      cpl_drop   <= cpl_valid && !cpl_hit;
      tmo_pulse  <= tmo_hit;
      tmo_tag    <= tmo_idx;
    end
  end

  // R3
  alloc_not_live_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> (st_q[req_tag] != TAG_PEND));
  // R7
  tmo_poisoned_chk: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |-> (st_q[tmo_tag] == TAG_POISON));
  // R6
  accept_drop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cpl_accept && cpl_drop));
  // R5
  hdr_balance_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(hdr_free) + $countones(pend_mask)) == HDR_CAP);
endmodule

// File: tb/test_rd_tag_tracker.sv
module test_rd_tag_tracker;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] timeout_cycles;
  logic        req_valid;
  logic [12:0] req_bytes;
  logic        req_ready;
  logic [4:0]  req_tag;
  logic        cpl_valid;
  logic [4:0]  cpl_tag;
  logic        cpl_last;
  logic        cpl_accept, cpl_drop, tmo_pulse;
  logic [4:0]  tmo_tag;
  logic [4:0]  hdr_free;
  logic [8:0]  data_free;

  int total = 0;
  int bad   = 0;

  always #5ns clk = ~clk;

  rd_tag_tracker i_rd_tag_tracker (
    .clk(clk), .rst(rst), .timeout_cycles(timeout_cycles),
    .req_valid(req_valid), .req_bytes(req_bytes), .req_ready(req_ready), .req_tag(req_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_last(cpl_last),
    .cpl_accept(cpl_accept), .cpl_drop(cpl_drop),
    .tmo_pulse(tmo_pulse), .tmo_tag(tmo_tag),
    .hdr_free(hdr_free), .data_free(data_free));

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2ns;
  endtask

  task automatic do_reset(input int t);
    rst = 1'b1; req_valid = 0; req_bytes = 0; cpl_valid = 0; cpl_tag = 0; cpl_last = 0;
    timeout_cycles = 16'(t);
    repeat (3) tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic issue(input int bytes, input int exp_tag, input string req);
    req_valid = 1'b1; req_bytes = 13'(bytes);
    #1ns;
    chk(req, "req_ready", int'(req_ready), 1);
    chk(req, "req_tag", int'(req_tag), exp_tag);
    tick();
    req_valid = 1'b0;
  endtask

  task automatic send_cpl(input int tag, input bit last, input bit exp_acc, input string req);
    cpl_valid = 1'b1; cpl_tag = 5'(tag); cpl_last = last;
    tick();
    cpl_valid = 1'b0; cpl_last = 1'b0;
    chk(req, "cpl_accept", int'(cpl_accept), int'(exp_acc));
    chk(req, "cpl_drop", int'(cpl_drop), int'(!exp_acc));
  endtask

  task automatic t_reset();
    do_reset(1000);
    chk("R1", "hdr_free", int'(hdr_free), 16);
    chk("R1", "data_free", int'(data_free), 256);
    chk("R1", "cpl_accept", int'(cpl_accept), 0);
    chk("R1", "cpl_drop", int'(cpl_drop), 0);
    chk("R1", "tmo_pulse", int'(tmo_pulse), 0);
    req_valid = 1'b1; req_bytes = 13'd16;
    #1ns;
    chk("R1", "req_ready", int'(req_ready), 1);
    chk("R1", "req_tag", int'(req_tag), 0);
    req_valid = 1'b0;
  endtask

  task automatic t_alloc_complete();
    do_reset(1000);
    issue(64, 0, "R3");
    issue(64, 1, "R3");
    issue(64, 2, "R3");
    chk("R2", "hdr_free", int'(hdr_free), 13);
    chk("R2", "data_free", int'(data_free), 244);
    send_cpl(1, 1'b0, 1'b1, "R4");
    chk("R4", "hdr_free after partial", int'(hdr_free), 13);
    send_cpl(1, 1'b1, 1'b1, "R5");
    chk("R5", "hdr_free", int'(hdr_free), 14);
    chk("R5", "data_free", int'(data_free), 248);
    send_cpl(9, 1'b1, 1'b0, "R6");
    chk("R6", "hdr_free", int'(hdr_free), 14);
    chk("R6", "data_free", int'(data_free), 248);
    issue(16, 1, "R3");
  endtask

  task automatic t_credit_limit();
    do_reset(1000);
    issue(4096, 0, "R2");
    chk("R2", "data_free", int'(data_free), 0);
    chk("R2", "hdr_free", int'(hdr_free), 15);
    req_valid = 1'b1; req_bytes = 13'd16;
    #1ns;
    chk("R2", "req_ready no data", int'(req_ready), 0);
    req_valid = 1'b0;
    send_cpl(0, 1'b1, 1'b1, "R5");
    chk("R5", "data_free", int'(data_free), 256);
    for (int i = 0; i < 16; i++) issue(17, i, "R3");
    chk("R2", "hdr_free", int'(hdr_free), 0);
    chk("R2", "data_free", int'(data_free), 224);
    req_valid = 1'b1; req_bytes = 13'd1;
    #1ns;
    chk("R2", "req_ready no hdr", int'(req_ready), 0);
    req_valid = 1'b0;
  endtask

  task automatic t_timeout();
    do_reset(1000);
    issue(32, 0, "R7");
    repeat (999) tick();
    chk("R7", "tmo_pulse early", int'(tmo_pulse), 0);
    tick();
    chk("R7", "tmo_pulse", int'(tmo_pulse), 1);
    chk("R7", "tmo_tag", int'(tmo_tag), 0);
    chk("R7", "hdr_free", int'(hdr_free), 16);
    chk("R7", "data_free", int'(data_free), 256);
    tick();
    chk("R7", "tmo_pulse one cycle", int'(tmo_pulse), 0);
    send_cpl(0, 1'b1, 1'b0, "R8");
    chk("R8", "data_free", int'(data_free), 256);
    issue(32, 0, "R3");
    send_cpl(0, 1'b1, 1'b1, "R8");
  endtask

  task automatic t_same_cycle();
    do_reset(20);
    issue(16, 0, "R9");
    repeat (20) tick();
    chk("R9", "tmo_pulse", int'(tmo_pulse), 1);
    req_valid = 1'b1; req_bytes = 13'd16;
    cpl_valid = 1'b1; cpl_tag = 5'd0; cpl_last = 1'b1;
    #1ns;
    chk("R9", "req_tag reuse", int'(req_tag), 0);
    tick();
    req_valid = 1'b0; cpl_valid = 1'b0; cpl_last = 1'b0;
    chk("R9", "cpl_drop old state", int'(cpl_drop), 1);
    chk("R9", "cpl_accept old state", int'(cpl_accept), 0);
    send_cpl(0, 1'b1, 1'b1, "R9");
    issue(16, 0, "R9");
    req_valid = 1'b1; req_bytes = 13'd16;
    cpl_valid = 1'b1; cpl_tag = 5'd0; cpl_last = 1'b1;
    #1ns;
    chk("R9", "req_tag while live", int'(req_tag), 1);
    tick();
    req_valid = 1'b0; cpl_valid = 1'b0; cpl_last = 1'b0;
    chk("R9", "cpl_accept", int'(cpl_accept), 1);
    chk("R9", "hdr_free", int'(hdr_free), 15);
  endtask

  task automatic t_multi_expire();
    do_reset(21);
    issue(16, 0, "R10");
    timeout_cycles = 16'd20;
    issue(16, 1, "R10");
    repeat (19) tick();
    chk("R10", "tmo_pulse early", int'(tmo_pulse), 0);
    tick();
    chk("R10", "first tmo_pulse", int'(tmo_pulse), 1);
    chk("R10", "first tmo_tag", int'(tmo_tag), 0);
    tick();
    chk("R10", "second tmo_pulse", int'(tmo_pulse), 1);
    chk("R10", "second tmo_tag", int'(tmo_tag), 1);
    tick();
    chk("R10", "tmo_pulse after", int'(tmo_pulse), 0);
    chk("R10", "hdr_free", int'(hdr_free), 16);
  endtask

  task automatic t_race();
    do_reset(20);
    issue(48, 0, "R11");
    repeat (19) tick();
    cpl_valid = 1'b1; cpl_tag = 5'd0; cpl_last = 1'b1;
    tick();
    cpl_valid = 1'b0; cpl_last = 1'b0;
    chk("R11", "cpl_accept", int'(cpl_accept), 1);
    chk("R11", "tmo_pulse", int'(tmo_pulse), 0);
    tick();
    chk("R11", "tmo_pulse later", int'(tmo_pulse), 0);
    chk("R11", "hdr_free", int'(hdr_free), 16);
    chk("R11", "data_free", int'(data_free), 256);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_alloc_complete();
    t_credit_limit();
    t_timeout();
    t_same_cycle();
    t_multi_expire();
    t_race();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule